// File: doc/BRIEF.md
# Bit Field Execution Unit

This unit performs the eight register-operand bit field operations of a 32-bit integer core: unsigned extract, signed extract, insert, set, clear, complement, test and find-first-one. A field is a run of 1 to 32 adjacent bits. It is named by an offset and a width. Offsets count from the operand's most significant bit downward, so field bit 0 is the leftmost bit, and a field that runs off the low end of the word continues at the top.

Each request presents an opcode, a destination operand, a source register, an offset and a width, together with a one-cycle `valid_i` strobe. On the next clock edge the unit registers three things: the possibly modified operand, a 32-bit register result, and the N and Z condition flags. It also raises `done_o` for that cycle. A small control machine tracks this. In state S_IDLE no result is pending. A strobe moves it to S_DONE, where `done_o` is high. In S_DONE a further strobe keeps it in S_DONE, which lets back-to-back issue run at full rate. With no strobe it returns to S_IDLE. With no strobe in S_IDLE it stays in S_IDLE. Registered outputs hold their last values until the next strobe.

Top module: `bitfield_unit`

## Requirements
- R1: Field bit k (k = 0..w-1) is operand bit 31 - ((offset + k) mod 32). The offset is 5 bits wide. A width code of 0 means 32. A field that passes integer bit 0 continues at integer bit 31.
- R2: Opcode 0 (unsigned extract) returns the field in `reg_o` bits w-1..0, with field bit 0 at bit w-1 and zeros above. The operand is unchanged.
- R3: Opcode 1 (signed extract) returns the field as in R2, but every bit above w-1 copies field bit 0.
- R4: Opcode 2 (insert) writes source bits w-1..0 into the field, with source bit w-1 going to field bit 0. All other operand bits keep their values. `reg_o` is 0.
- R5: Opcodes 3, 4 and 5 (set, clear, complement) make every field bit 1, 0 or its inverse. All other bits are unchanged and `reg_o` is 0.
- R6: Opcode 6 (test) returns the operand unchanged and `reg_o` as 0.
- R7: Opcode 7 (find first one) returns offset + k in `reg_o`, where k is the lowest-numbered field bit that is 1. If no field bit is 1 it returns offset + w, with w in the range 1..32. The operand is unchanged.
- R8: For every opcode, `n_o` is field bit 0 and `z_o` is 1 exactly when all field bits are 0. Both flags are taken from the operand before any change.
- R9: Results and a one-cycle `done_o` appear on the clock edge after `valid_i`. Back-to-back strobes give back-to-back results. Without a strobe, `done_o` is 0 and all other outputs hold.
- R10: A synchronous reset clears `done_o`, `opnd_o`, `reg_o`, `n_o` and `z_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0..7) |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Source register for insert |
| off_i | input | 5 | Field offset from the MSB |
| wid_i | input | 5 | Field width, 0 meaning 32 |
| done_o | output | 1 | Result valid pulse |
| opnd_o | output | 32 | Updated operand |
| reg_o | output | 32 | Register result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |

## Verification
Some properties are checked by assertions on every cycle. `done_o` must follow a strobe exactly one edge later and must never appear without one. Test must return the operand untouched. Unsigned extract must leave nothing above the field width. A find-first-one result must never exceed offset plus width. The exact bit placement for each offset and width is shown only by the bench's scenarios. This covers wrap-around fields, full 32-bit fields, sign copying, insertion that preserves neighbouring bits, empty-field find results, flags taken before modification, and the output hold during idle cycles. The bench checks these against its own bit-by-bit model.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    typedef enum logic [2:0] {
        OP_EXTU = 3'd0,
        OP_EXTS = 3'd1,
        OP_INS  = 3'd2,
        OP_SET  = 3'd3,
        OP_CLR  = 3'd4,
        OP_CHG  = 3'd5,
        OP_TST  = 3'd6,
        OP_FFO  = 3'd7
    } bfu_op_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_DONE = 1'b1
    } bfu_state_e;
endpackage

// File: rtl/bfu_rotate.sv
module bfu_rotate #(
    parameter int DW   = 32,
    parameter int SW   = 5,
    parameter bit LEFT = 1'b1
) (
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] amt,
    output logic [DW-1:0] dout
);
    logic [2*DW-1:0] dbl;

    generate
        if (LEFT) begin : g_left
            assign dbl  = {din, din} << amt;
            assign dout = dbl[2*DW-1:DW];
        end else begin : g_right
            assign dbl  = {din, din} >> amt;
            assign dout = dbl[DW-1:0];
        end
    endgenerate
endmodule

// File: rtl/bfu_lowmask.sv
module bfu_lowmask #(
    parameter int DW = 32,
    parameter int WW = 6
) (
    input  logic [WW-1:0] width,
    output logic [DW-1:0] mask
);
    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            assign mask[i] = (WW'(i) < width);
        end
    endgenerate
endmodule

// File: rtl/bfu_msb_find.sv
module bfu_msb_find #(
    parameter int DW = 32,
    parameter int IW = 5
) (
    input  logic [DW-1:0] din,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < DW; i++) begin
            if (din[i]) idx = IW'(i);
        end
    end

    assign found = |din;
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DW = 32,
    localparam int OW = $clog2(DW),
    localparam int WW = OW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    input  logic [OW-1:0] off_i,
    input  logic [OW-1:0] wid_i,
    output logic          done_o,
    output logic [DW-1:0] opnd_o,
    output logic [DW-1:0] reg_o,
    output logic          n_o,
    output logic          z_o
);
    bfu_state_e state_q, state_d;

    logic [WW-1:0] eff_w;
    logic [OW-1:0] rot_amt;
    logic [DW-1:0] aligned, lmask, field, topbit;
    logic [DW-1:0] place_mask, ins_val, ffo_res;
    logic [DW-1:0] opnd_d, reg_d;
    logic          n_bit, z_bit, ffo_found;
    logic [OW-1:0] ffo_idx;

    assign eff_w   = (wid_i == '0) ? WW'(DW) : {1'b0, wid_i};
    assign rot_amt = off_i + eff_w[OW-1:0];

    bfu_lowmask #(.DW(DW), .WW(WW)) u_mask (
        .width(eff_w), .mask(lmask)
    );

    bfu_rotate #(.DW(DW), .SW(OW), .LEFT(1'b1)) u_align (
        .din(dst_i), .amt(rot_amt), .dout(aligned)
    );

    bfu_rotate #(.DW(DW), .SW(OW), .LEFT(1'b0)) u_place (
        .din(lmask), .amt(rot_amt), .dout(place_mask)
    );

    bfu_rotate #(.DW(DW), .SW(OW), .LEFT(1'b0)) u_ins (
        .din(src_i & lmask), .amt(rot_amt), .dout(ins_val)
    );

    assign field  = aligned & lmask;
    assign topbit = lmask ^ (lmask >> 1);
    assign n_bit  = |(aligned & topbit);
    assign z_bit  = ~|field;

    bfu_msb_find #(.DW(DW), .IW(OW)) u_ffo (
        .din(field), .found(ffo_found), .idx(ffo_idx)
    );

    assign ffo_res = DW'(off_i) +
        (ffo_found ? (DW'(eff_w) - DW'(1) - DW'(ffo_idx)) : DW'(eff_w));

    always_comb begin
        opnd_d = dst_i;
        reg_d  = '0;
        unique case (op_i)
            OP_EXTU: reg_d  = field;
            OP_EXTS: reg_d  = field | (n_bit ? ~lmask : '0);
            OP_INS:  opnd_d = (dst_i & ~place_mask) | ins_val;
            OP_SET:  opnd_d = dst_i | place_mask;
            OP_CLR:  opnd_d = dst_i & ~place_mask;
            OP_CHG:  opnd_d = dst_i ^ place_mask;
            OP_TST:  opnd_d = dst_i;
            OP_FFO:  reg_d  = ffo_res;
            default: opnd_d = dst_i;
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = valid_i ? S_DONE : S_IDLE;
            S_DONE:  state_d = valid_i ? S_DONE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_o <= '0;
            reg_o  <= '0;
            n_o    <= 1'b0;
            z_o    <= 1'b0;
        end else if (valid_i) begin
            opnd_o <= opnd_d;
            reg_o  <= reg_d;
            n_o    <= n_bit;
            z_o    <= z_bit;
        end
    end

    assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker
    import bfu_pkg::*;
#(
    parameter int DW = 32,
    localparam int OW = $clog2(DW),
    localparam int WW = OW + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_i,
    input logic [2:0]    op_i,
    input logic [DW-1:0] dst_i,
    input logic [OW-1:0] off_i,
    input logic [OW-1:0] wid_i,
    input logic          done_o,
    input logic [DW-1:0] opnd_o,
    input logic [DW-1:0] reg_o
);
    logic [WW-1:0] cw;
    logic [DW-1:0] ffo_lim;

    assign cw      = (wid_i == '0) ? WW'(DW) : {1'b0, wid_i};
    assign ffo_lim = DW'(off_i) + DW'(cw);

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o); // R9

    AST_NO_DONE_WITHOUT_VALID: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o); // R9

    AST_TEST_KEEPS_OPERAND: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_TST) |=> (opnd_o == $past(dst_i) && reg_o == '0)); // R6

    AST_EXTU_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_EXTU) |=> ((reg_o >> $past(cw)) == '0)); // R2

    AST_FFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_FFO) |=> (reg_o <= $past(ffo_lim))); // R7

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(opnd_o) && $stable(reg_o))); // R9
endmodule

bind bitfield_unit bfu_checker #(.DW(DW)) u_bfu_checker (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .dst_i(dst_i),
    .off_i(off_i), .wid_i(wid_i), .done_o(done_o), .opnd_o(opnd_o),
    .reg_o(reg_o)
);

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
    import bfu_pkg::*;

    typedef struct {
        logic [31:0] opnd;
        logic [31:0] regv;
        logic        n;
        logic        z;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] dst_i = '0, src_i = '0;
    logic [4:0]  off_i = '0, wid_i = '0;
    logic        done_o, n_o, z_o;
    logic [31:0] opnd_o, reg_o;

    int   compared = 0;
    int   mismatched = 0;
    bit   finished = 0;
    exp_t exp_q[$];
    exp_t last_e;

    always #2 clk = ~clk;

    bitfield_unit i_bitfield_unit (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .dst_i(dst_i),
        .src_i(src_i), .off_i(off_i), .wid_i(wid_i), .done_o(done_o),
        .opnd_o(opnd_o), .reg_o(reg_o), .n_o(n_o), .z_o(z_o)
    );

    function automatic exp_t model(bfu_op_e op, logic [31:0] d, logic [31:0] s,
                                   int off, int wid, string tag);
        exp_t e;
        int w;
        logic [31:0] fv;
        w = (wid == 0) ? 32 : wid;
        fv = '0;
        for (int k = 0; k < w; k++) fv = {fv[30:0], d[31 - ((off + k) % 32)]};
        e.n    = d[31 - off];
        e.z    = (fv == 0);
        e.opnd = d;
        e.regv = '0;
        e.tag  = tag;
        case (op)
            OP_EXTU: e.regv = fv;
            OP_EXTS: begin
                e.regv = fv;
                for (int b = w; b < 32; b++) e.regv[b] = e.n;
            end
            OP_INS: for (int k = 0; k < w; k++) e.opnd[31 - ((off + k) % 32)] = s[w - 1 - k];
            OP_SET: for (int k = 0; k < w; k++) e.opnd[31 - ((off + k) % 32)] = 1'b1;
            OP_CLR: for (int k = 0; k < w; k++) e.opnd[31 - ((off + k) % 32)] = 1'b0;
            OP_CHG: for (int k = 0; k < w; k++)
                        e.opnd[31 - ((off + k) % 32)] = ~d[31 - ((off + k) % 32)];
            OP_FFO: begin
                e.regv = 32'(off + w);
                for (int k = w - 1; k >= 0; k--)
                    if (d[31 - ((off + k) % 32)]) e.regv = 32'(off + k);
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic send(bfu_op_e op, logic [31:0] d, logic [31:0] s,
                        int off, int wid, string tag);
        @(negedge clk);
        valid_i = 1'b1;
        op_i    = op;
        dst_i   = d;
        src_i   = s;
        off_i   = 5'(off);
        wid_i   = 5'(wid);
        last_e  = model(op, d, s, off, wid, tag);
        exp_q.push_back(last_e);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        valid_i = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    compared++; mismatched++;
                    $display("FAIL R9: done_o high with no request pending");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    compared++;
                    if (opnd_o !== e.opnd || reg_o !== e.regv || n_o !== e.n || z_o !== e.z) begin
                        mismatched++;
                        $display("FAIL %s: opnd=%h reg=%h n=%b z=%b expected opnd=%h reg=%h n=%b z=%b",
                                 e.tag, opnd_o, reg_o, n_o, z_o, e.opnd, e.regv, e.n, e.z);
                    end
                end
            end else if (exp_q.size() != 0) begin
                void'(exp_q.pop_front());
                compared++; mismatched++;
                $display("FAIL R9: done_o=0 one edge after valid, expected 1");
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compared++;
        if (done_o !== 1'b0 || opnd_o !== '0 || reg_o !== '0 || n_o !== 1'b0 || z_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R10: after reset done=%b opnd=%h reg=%h n=%b z=%b expected all 0",
                     done_o, opnd_o, reg_o, n_o, z_o);
        end

        send(OP_EXTU, 32'hA512_3456, 32'h0, 0, 8, "R2");
        send(OP_EXTU, 32'hA512_3456, 32'h0, 12, 4, "R1");
        send(OP_EXTU, 32'hA512_3456, 32'h0, 5, 0, "R1");
        send(OP_EXTU, 32'h1234_56F8, 32'h0, 28, 8, "R1");
        send(OP_EXTS, 32'h9000_0000, 32'h0, 0, 4, "R3");
        send(OP_EXTS, 32'h9500_0000, 32'h0, 4, 4, "R3");
        send(OP_EXTS, 32'h0000_0003, 32'h0, 30, 4, "R3");
        idle(2);
        send(OP_INS, 32'h1122_3344, 32'hFFFF_FF3C, 8, 8, "R4");
        send(OP_INS, 32'h1122_3344, 32'h0000_000A, 30, 4, "R4");
        send(OP_INS, 32'h1122_3344, 32'hCAFE_BABE, 7, 0, "R4");
        send(OP_SET, 32'h0F0F_0F0F, 32'h0, 6, 10, "R5");
        send(OP_CLR, 32'hFFFF_FFFF, 32'h0, 29, 6, "R5");
        send(OP_CHG, 32'h8001_0000, 32'h0, 0, 0, "R5");
        idle(1);
        send(OP_TST, 32'hDEAD_BEEF, 32'h0, 3, 9, "R6");
        send(OP_TST, 32'hFF00_FFFF, 32'h0, 8, 8, "R8");
        send(OP_TST, 32'h0080_0000, 32'h0, 8, 4, "R8");
        send(OP_SET, 32'h0000_0000, 32'h0, 16, 8, "R8");
        send(OP_FFO, 32'h0008_0000, 32'h0, 4, 20, "R7");
        send(OP_FFO, 32'hF000_000F, 32'h0, 4, 24, "R7");
        send(OP_FFO, 32'h4000_0000, 32'h0, 30, 6, "R7");
        send(OP_FFO, 32'h0000_0000, 32'h0, 17, 0, "R7");
        send(OP_FFO, 32'h8000_0000, 32'h0, 0, 0, "R7");
        idle(4);
        compared++;
        if (done_o !== 1'b0 || opnd_o !== last_e.opnd || reg_o !== last_e.regv) begin
            mismatched++;
            $display("FAIL R9: idle done=%b opnd=%h reg=%h expected done=0 opnd=%h reg=%h",
                     done_o, opnd_o, reg_o, last_e.opnd, last_e.regv);
        end
        send(OP_INS, 32'h0000_0000, 32'hFFFF_FFFF, 0, 1, "R10");
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        compared++;
        if (done_o !== 1'b0 || opnd_o !== '0 || reg_o !== '0 || n_o !== 1'b0 || z_o !== 1'b0) begin
            mismatched++;
            $display("FAIL R10: mid-run reset done=%b opnd=%h reg=%h n=%b z=%b expected all 0",
                     done_o, opnd_o, reg_o, n_o, z_o);
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            compared++; mismatched++;
            $display("FAIL R9: watchdog expired, run hung");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule